// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Controller

This block gathers interrupt requests from a set of peripheral sources into one pending register and drives one active-high interrupt level to a CPU. A source marks its bit pending with a one-cycle set pulse. It later withdraws the request with a clear pulse. Once set, a bit stays pending until it is explicitly cleared.

The pending register has two groups. The low group of maskable bits reaches the CPU line only through a software-written enable mask. The high group is non-maskable: any pending bit there raises the line whatever the mask holds. The CPU reaches the block through a small register port. One address selects the enable mask, which can be written and read. The other address selects the pending state, which is read-only and shows only the maskable group.

The block has no sequencing states. Its behaviour is two sticky registers and a registered output term. The set-dominant update rule and the one-cycle output delay are the only ordering rules.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable mask is 0x00, every pending bit is 0 and `cpu_irq` is 0.
- R2: A set pulse ORs `src_set` into the pending register. Bits that were already pending stay set.
- R3: A clear pulse clears exactly the bits that are 1 in `src_clr`. All other pending bits keep their value.
- R4: When a bit is named by `src_set` and `src_clr` in the same cycle, the bit ends up pending (set dominates).
- R5: A write with `reg_addr` = 0 loads all 8 bits of `reg_wdata` into the enable mask. A read with `reg_addr` = 0 returns the mask on `reg_rdata`.
- R6: A read with `reg_addr` = 1 returns pending bits [7:0] on `reg_rdata`. Pending bits [15:8] never appear on the read port.
- R7: A write with `reg_addr` = 1 leaves the pending register unchanged.
- R8: A maskable pending bit i (0..7) raises `cpu_irq` only when enable bit i is 1.
- R9: Any pending bit in [15:8] raises `cpu_irq` regardless of the enable mask.
- R10: `cpu_irq` is registered. In the cycle after a clock edge it equals (|(pending[7:0] & enable)) | (|pending[15:8]), taken from the register values that were in place before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 16 | Per-bit set pulses from sources |
| src_clr | input | 16 | Per-bit clear pulses from sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable mask, 1 pending state |
| reg_wdata | input | 8 | Write data for the enable mask |
| reg_rdata | output | 8 | Read data for the selected register |
| cpu_irq | output | 1 | Interrupt level to the CPU, active high |

## Verification
Two pairs of operations can land in the same cycle. The first pair is a set and a clear that name the same bit. The bench drives both vectors in one cycle with that bit in each, and expects the bit still pending when it is read back. The second pair is a pending-address write and a source update. The bench writes 0xFF to the pending address and reads the pending state afterwards; it must be unchanged. The checker also confirms that a mask write and a pending change in the same cycle both show on `cpu_irq` exactly one cycle later.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    // Register port address decode; the bench and software rely on these codes.
    localparam logic ADDR_ENABLE  = 1'b0;
    localparam logic ADDR_PENDING = 1'b1;

    // Reset value of the enable mask and pending bits.
    localparam logic RESET_BIT = 1'b0;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);
    import irq_agg_pkg::*;

    // One sticky flop per source; set dominates clear.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= RESET_BIT;
            end else if (set_i[b]) begin
                bit_q <= 1'b1;
            end else if (clr_i[b]) begin
                bit_q <= 1'b0;
            end
        end
        assign pend_o[b] = bit_q;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] mask_o
);
    import irq_agg_pkg::*;

    logic [WIDTH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= {WIDTH{RESET_BIT}};
        end else if (load_i) begin
            mask_q <= data_i;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int MASK_W = 8,
    parameter int NMI_W  = 8,
    localparam int PEND_W = MASK_W + NMI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] pend_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              irq_o
);
    import irq_agg_pkg::*;

    logic maskable_hit;
    logic nmi_hit;
    logic irq_q;

    always_comb begin
        maskable_hit = |(pend_i[MASK_W-1:0] & mask_i);
        nmi_hit      = |pend_i[PEND_W-1:MASK_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= RESET_BIT;
        end else begin
            irq_q <= maskable_hit | nmi_hit;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int MASK_W = 8,
    parameter int NMI_W  = 8,
    localparam int PEND_W = MASK_W + NMI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] src_set,
    input  logic [PEND_W-1:0] src_clr,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [MASK_W-1:0] reg_wdata,
    output logic [MASK_W-1:0] reg_rdata,
    output logic              cpu_irq
);
    import irq_agg_pkg::*;

    logic [PEND_W-1:0] pend_q;
    logic [MASK_W-1:0] en_q;
    logic              mask_load;

    // Writes to the pending address decode to nothing.
    assign mask_load = reg_wr && (reg_addr == ADDR_ENABLE);

    irq_pend_bank #(.WIDTH(PEND_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (src_clr),
        .pend_o (pend_q)
    );

    irq_mask_reg #(.WIDTH(MASK_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mask_load),
        .data_i (reg_wdata),
        .mask_o (en_q)
    );

    irq_line_gen #(.MASK_W(MASK_W), .NMI_W(NMI_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .mask_i (en_q),
        .irq_o  (cpu_irq)
    );

    // Read port: only the maskable group of pending bits is visible.
    always_comb begin
        unique case (reg_addr)
            ADDR_ENABLE:  reg_rdata = en_q;
            ADDR_PENDING: reg_rdata = pend_q[MASK_W-1:0];
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int MASK_W = 8,
    parameter int NMI_W  = 8,
    localparam int PEND_W = MASK_W + NMI_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] src_set,
    input logic [PEND_W-1:0] src_clr,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [MASK_W-1:0] reg_wdata,
    input logic              cpu_irq,
    input logic [PEND_W-1:0] pend_q,
    input logic [MASK_W-1:0] en_q
);
    // R2 / R4: every requested bit is pending one cycle later.
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((pend_q & $past(src_set)) == $past(src_set)));

    // R3: bits cleared without a competing set are gone one cycle later.
    p_clear_named_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_clr & ~src_set) != '0) |=> ((pend_q & $past(src_clr & ~src_set)) == '0));

    // R5: an enable-address write loads the whole mask.
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 1'b0) |=> (en_q == $past(reg_wdata)));

    // R7: a pending-address write with no source activity leaves pending alone.
    p_pend_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 1'b1 && src_set == '0 && src_clr == '0) |=> $stable(pend_q));

    // R9: a non-maskable pending bit raises the line next cycle.
    p_nmi_reaches_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q[PEND_W-1:MASK_W]) |=> cpu_irq);

    // R8 / R10: with nothing enabled and pending, the line is low next cycle.
    p_line_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_q[MASK_W-1:0] & en_q) == '0) && (pend_q[PEND_W-1:MASK_W] == '0)) |=> !cpu_irq);

    // R8 / R10: an enabled maskable pending bit raises the line next cycle.
    p_line_masked_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q[MASK_W-1:0] & en_q) != '0) |=> cpu_irq);
endmodule

bind irq_aggregator irq_aggregator_chk #(.MASK_W(MASK_W), .NMI_W(NMI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set   (src_set),
    .src_clr   (src_clr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cpu_irq   (cpu_irq),
    .pend_q    (pend_q),
    .en_q      (en_q)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    localparam int MASK_W = 8;
    localparam int NMI_W  = 8;
    localparam int PEND_W = MASK_W + NMI_W;

    typedef struct {
        logic [MASK_W-1:0] exp_rdata;
        logic              exp_irq;
        string             tag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PEND_W-1:0] src_set = '0;
    logic [PEND_W-1:0] src_clr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_addr = 1'b0;
    logic [MASK_W-1:0] reg_wdata = '0;
    logic [MASK_W-1:0] reg_rdata;
    logic              cpu_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    exp_item_t         sb_q[$];
    logic [PEND_W-1:0] m_pend = '0;
    logic [MASK_W-1:0] m_en   = '0;

    always #5 clk = ~clk;

    irq_aggregator #(.MASK_W(MASK_W), .NMI_W(NMI_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_set   (src_set),
        .src_clr   (src_clr),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_irq   (cpu_irq)
    );

    function automatic logic line_of(logic [PEND_W-1:0] p, logic [MASK_W-1:0] e);
        return (|(p[MASK_W-1:0] & e)) | (|p[PEND_W-1:MASK_W]);
    endfunction

    // Driver: one clock of stimulus, model update, expectation pushed.
    task automatic step(input logic [PEND_W-1:0] s, input logic [PEND_W-1:0] c,
                        input logic wr, input logic addr,
                        input logic [MASK_W-1:0] wd, input string tag);
        exp_item_t it;
        @(negedge clk);
        src_set   = s;
        src_clr   = c;
        reg_wr    = wr;
        reg_addr  = addr;
        reg_wdata = wd;
        it.exp_irq = line_of(m_pend, m_en);
        m_pend = (m_pend & ~c) | s;
        if (wr && addr == 1'b0) m_en = wd;
        it.exp_rdata = addr ? m_pend[MASK_W-1:0] : m_en;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: samples 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (reg_rdata !== it.exp_rdata) begin
                    errors++;
                    $display("FAIL %s rdata: actual=%h expected=%h", it.tag, reg_rdata, it.exp_rdata);
                end
                checks++;
                if (cpu_irq !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s irq (R10 timing): actual=%b expected=%b", it.tag, cpu_irq, it.exp_irq);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of mask, pending and line
        step('0, '0, 1'b0, 1'b0, 8'h00, "R1");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R1");
        // R2: set accumulates; R8: mask closed keeps the line low
        step(16'h0005, '0, 1'b0, 1'b1, 8'h00, "R2");
        step(16'h0010, '0, 1'b0, 1'b1, 8'h00, "R2");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R8");
        // R5: full-width mask load and readback
        step('0, '0, 1'b1, 1'b0, 8'hA4, "R5");
        step('0, '0, 1'b0, 1'b0, 8'h00, "R8");
        step('0, '0, 1'b0, 1'b0, 8'h00, "R8");
        // R8: mask enables only non-pending bits -> line low
        step('0, '0, 1'b1, 1'b0, 8'h4A, "R5");
        step('0, '0, 1'b0, 1'b0, 8'h00, "R8");
        step('0, '0, 1'b1, 1'b0, 8'h00, "R5");
        step('0, '0, 1'b0, 1'b0, 8'h00, "R8");
        // R9 / R6: non-maskable bit raises the line and stays hidden
        step(16'h0100, '0, 1'b0, 1'b1, 8'h00, "R6");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R9");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R9");
        // R3: clear only the named bits
        step('0, 16'h0104, 1'b0, 1'b1, 8'h00, "R3");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R3");
        // R4: set and clear of the same bit in one cycle
        step(16'h0002, 16'h0002, 1'b0, 1'b1, 8'h00, "R4");
        step(16'h8000, 16'h8001, 1'b0, 1'b1, 8'h00, "R4");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R4");
        // R7: write to pending address ignored
        step('0, '0, 1'b1, 1'b1, 8'hFF, "R7");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R7");
        step('0, '0, 1'b0, 1'b0, 8'h00, "R7");
        // Drain everything; line must fall
        step('0, 16'hFFFF, 1'b0, 1'b1, 8'h00, "R3");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R10");
        step('0, '0, 1'b0, 1'b1, 8'h00, "R10");
        @(negedge clk);
        src_clr = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #2000000;
        join_any
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule